// File: doc/BRIEF.md
# Freezable Event Counter Bank

A performance-monitor block for a memory controller. It holds eleven counters that software reaches through a plain 32-bit register port with byte offsets. Lane 0 is a 64-bit counter that ticks on every clock. Lanes 1 to 10 are 32-bit counters. Each of them picks one line from a 128-bit bank of event pulses and adds one on every clock in which that line is high.

Counting is gated by two freeze levels. The first is a global freeze bit that covers all lanes and overrides everything else. The second is a freeze bit in each lane's own control word. An overflow is a counter's top bit moving from 0 to 1 through counting. When the lane's condition enable and both global enables are set, an overflow makes hardware set the global freeze bit. It also raises a level interrupt, which stays high until software clears that counter's top bit.

Because the cycle counter is wider than the port, reading its lower word copies the upper word into a holding register. A later read of the upper word then returns a pair that belongs together.

Top module: `evtctr_bank`

## Requirements
- R1: After reset the global word reads 0x8000_0000 (global freeze set, interrupt enable and freeze-on-overflow clear). Every lane control word reads 0, every count reads 0, and irq is 0.
- R2: Register map, with read data valid one clock after rd_en. Global word at 0x40: bit 31 global freeze, bit 30 interrupt enable, bit 29 freeze-on-overflow. For lane n, the control word is at 0x50+16n: bit 31 lane freeze, bit 26 condition enable, bits 22:16 event code. The count is at 0x58+16n. The spare word at 0x54+16n always reads 0 and ignores writes.
- R3: A lane's count stays still while the global freeze or its own lane freeze is set. The global freeze overrides a clear lane freeze.
- R4: Lane 0 adds one on every unfrozen clock, whatever its event code holds.
- R5: Lanes 1 to 10 add one on each unfrozen clock where evt_in[code] is high, for codes 1 to 127. Code 0 counts every unfrozen clock. A lane whose selected line stays low keeps its count.
- R6: A write to a count register loads it, and the load wins over an increment in the same clock. The lower half of lane 0 is at 0x58 and the upper half at 0x5C, and each is written on its own.
- R7: An increment that moves a lane's top bit from 0 to 1 while that lane's condition enable, the global interrupt enable and freeze-on-overflow are all 1 sets the global freeze in the same clock. From then on every lane stops.
- R8: irq is high while both global enables are 1 and some lane has a recorded overflow (R7) whose top bit is still 1. Writing that count with top bit 0 drops irq on the next clock. Writing only the global word does not drop it.
- R9: With the lane's condition enable at 0, an overflow neither freezes the bank nor raises irq, and the lane keeps counting past it.
- R10: Reading 0x58 copies lane 0's upper half into a holding register. Reading 0x5C returns that held value, even if the upper half has since been written.
- R11: Addresses outside the map read 0. These include 0x00, 0x44, and the upper-half slot of any lane other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after rd_en |
| evt_in | input | 128 | Event pulse lines, one per event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
A wrong freeze state shows up at the ports as a count that is larger or smaller than the exact number of unfrozen clocks. The bench sees this at the first read after a counting window whose length it knows. A pending flag that fails to set or to clear shows on irq the clock after the overflow or the clearing write. A holding register that is not updated, or is updated at the wrong time, shows as an upper word that does not match what was written. The bench catches this with a read order that writes the upper half between the lower-half read and the upper-half read.

// File: rtl/evtctr_pkg.sv
// Shared constants for the event counter bank: register offsets and bit positions.
// Assumes an 8-bit byte address; lanes start at the high nibble LANE_HI0.
package evtctr_pkg;
    localparam logic [7:0] GLB_OFS  = 8'h40;
    localparam logic [3:0] LANE_HI0 = 4'h5;
    localparam logic [3:0] SUB_CTLA = 4'h0;
    localparam logic [3:0] SUB_CTLB = 4'h4;
    localparam logic [3:0] SUB_CNT  = 4'h8;
    localparam logic [3:0] SUB_CHI  = 4'hC;
    localparam int FRZ_BIT = 31;
    localparam int IE_BIT  = 30;
    localparam int FCE_BIT = 29;
    localparam int CE_BIT  = 26;
    localparam int SEL_LSB = 16;
endpackage

// File: rtl/evtctr_lane.sv
// One counter lane: local control word, event select and a W-bit count.
// Assumes W is 32, or larger than 32 with an upper part of at most 32 bits.
// Software loads win over increments. Reports an overflow that is gated by its
// condition enable, and keeps a pending flag until the top bit is cleared.
module evtctr_lane #(
    parameter int W          = 32,
    parameter int NEVT       = 128,
    parameter int SELW       = 7,
    parameter bit CYCLE_ONLY = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gfrz,
    input  logic            wr_ctla,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [31:0]     wdata,
    input  logic [NEVT-1:0] evt_in,
    output logic [31:0]     ctla_q,
    output logic [W-1:0]    cnt_q,
    output logic            ovf_ce,
    output logic            pend
);
    import evtctr_pkg::*;

    logic            lfrz;
    logic            ce;
    logic [SELW-1:0] sel;
    logic            hit;
    logic            inc;
    logic            wr_any;
    logic [W-1:0]    wr_val;
    logic [W-1:0]    cnt_inc;
    logic [W-1:0]    cnt_nx;
    logic            ovf;

    // Local control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfrz <= 1'b0;
            ce   <= 1'b0;
            sel  <= '0;
        end else if (wr_ctla) begin
            lfrz <= wdata[FRZ_BIT];
            ce   <= wdata[CE_BIT];
            sel  <= wdata[SEL_LSB +: SELW];
        end
    end

    // Read-back image of the control word
    always_comb begin
        ctla_q               = '0;
        ctla_q[FRZ_BIT]      = lfrz;
        ctla_q[CE_BIT]       = ce;
        ctla_q[SEL_LSB +: SELW] = sel;
    end

    // Selected event: the cycle lane and code 0 count every clock
    always_comb begin
        if (CYCLE_ONLY || sel == '0) hit = 1'b1;
        else                         hit = evt_in[sel];
    end

    assign inc     = hit && !gfrz && !lfrz;
    assign wr_any  = wr_lo || wr_hi;
    assign cnt_inc = cnt_q + W'(1);

    // Merge of software load data, per half where the count is wide
    generate
        if (W > 32) begin : g_wide
            assign wr_val = {wr_hi ? wdata[W-33:0] : cnt_q[W-1:32],
                             wr_lo ? wdata : cnt_q[31:0]};
        end else begin : g_narrow
            assign wr_val = wdata[W-1:0];
        end
    endgenerate

    assign cnt_nx = wr_any ? wr_val : (inc ? cnt_inc : cnt_q);
    assign ovf    = inc && !wr_any && !cnt_q[W-1] && cnt_inc[W-1];
    assign ovf_ce = ovf && ce;

    // Count and pending-overflow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pend  <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            pend  <= (pend || ovf_ce) && cnt_nx[W-1];
        end
    end

    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((gfrz || lfrz) && !wr_any) |=> $stable(cnt_q));
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));
    a_r8_pend_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> cnt_q[W-1]);
endmodule

// File: rtl/evtctr_glob.sv
// Global control: freeze-all, interrupt enable, freeze-on-overflow, and irq.
// Assumes overflow and pending inputs come straight from the lanes.
// A hardware trip on overflow wins over a software write of the freeze bit.
module evtctr_glob (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_glb,
    input  logic [2:0]  wbits,
    input  logic        ovf_any,
    input  logic        pend_any,
    output logic        gfrz,
    output logic [31:0] glb_q,
    output logic        irq
);
    logic gie;
    logic gfce;
    logic trip;

    assign trip = gie && gfce && ovf_any;

    // Global control bits; an overflow trip forces the freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gfrz <= 1'b1;
            gie  <= 1'b0;
            gfce <= 1'b0;
        end else begin
            if (wr_glb) begin
                gie  <= wbits[1];
                gfce <= wbits[0];
            end
            if (trip)        gfrz <= 1'b1;
            else if (wr_glb) gfrz <= wbits[2];
        end
    end

    assign glb_q = {gfrz, gie, gfce, 29'b0};
    assign irq   = gie && gfce && pend_any;

    a_r7_trip_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> gfrz);
endmodule

// File: rtl/evtctr_bank.sv
// Top of the event counter bank: address decode, read mux, cycle-counter
// holding register, lane array and global control.
// Assumes byte offsets on an 8-bit address, CW of 32 and CYW of 64.
module evtctr_bank #(
    parameter int NCNT = 11,
    parameter int CW   = 32,
    parameter int CYW  = 64,
    parameter int NEVT = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [7:0]      addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    input  logic [NEVT-1:0] evt_in,
    output logic            irq
);
    import evtctr_pkg::*;

    localparam int SELW = $clog2(NEVT);
    localparam int HIW  = CYW - 32;

    logic [3:0]      hi_nib;
    logic [3:0]      sub;
    logic [3:0]      lane_n;
    logic            lane_ok;
    logic            wr_glb;
    logic            gfrz;
    logic [31:0]     glb_q;
    logic [31:0]     ctla_a [NCNT];
    logic [31:0]     lo_a   [NCNT];
    logic [NCNT-1:0] ovf_v;
    logic [NCNT-1:0] pend_v;
    logic [HIW-1:0]  cyc_hi;
    logic [31:0]     shadow;
    logic [31:0]     rd_mux;

    assign hi_nib  = addr[7:4];
    assign sub     = addr[3:0];
    assign lane_n  = hi_nib - LANE_HI0;
    assign lane_ok = (hi_nib >= LANE_HI0) && ({28'b0, lane_n} < NCNT);
    assign wr_glb  = wr_en && (addr == GLB_OFS);

    generate
        for (genvar n = 0; n < NCNT; n++) begin : g_lane
            logic hit_n;
            assign hit_n = lane_ok && (lane_n == 4'(n));
            if (n == 0) begin : g_cyc
                logic [CYW-1:0] c0;
                evtctr_lane #(.W(CYW), .NEVT(NEVT), .SELW(SELW), .CYCLE_ONLY(1'b1)) u_lane (
                    .clk(clk), .rst_n(rst_n), .gfrz(gfrz),
                    .wr_ctla(wr_en && hit_n && sub == SUB_CTLA),
                    .wr_lo(wr_en && hit_n && sub == SUB_CNT),
                    .wr_hi(wr_en && hit_n && sub == SUB_CHI),
                    .wdata(wdata), .evt_in(evt_in),
                    .ctla_q(ctla_a[n]), .cnt_q(c0),
                    .ovf_ce(ovf_v[n]), .pend(pend_v[n])
                );
                assign lo_a[n] = c0[31:0];
                assign cyc_hi  = c0[CYW-1:32];
            end else begin : g_evt
                logic [CW-1:0] cn;
                evtctr_lane #(.W(CW), .NEVT(NEVT), .SELW(SELW), .CYCLE_ONLY(1'b0)) u_lane (
                    .clk(clk), .rst_n(rst_n), .gfrz(gfrz),
                    .wr_ctla(wr_en && hit_n && sub == SUB_CTLA),
                    .wr_lo(wr_en && hit_n && sub == SUB_CNT),
                    .wr_hi(1'b0),
                    .wdata(wdata), .evt_in(evt_in),
                    .ctla_q(ctla_a[n]), .cnt_q(cn),
                    .ovf_ce(ovf_v[n]), .pend(pend_v[n])
                );
                assign lo_a[n] = cn;
            end
        end
    endgenerate

    evtctr_glob u_glob (
        .clk(clk), .rst_n(rst_n), .wr_glb(wr_glb),
        .wbits(wdata[31:29]), .ovf_any(|ovf_v), .pend_any(|pend_v),
        .gfrz(gfrz), .glb_q(glb_q), .irq(irq)
    );

    // Holding register for the cycle counter upper half, loaded on a lower read
    always_ff @(posedge clk) begin
        if (!rst_n)                                               shadow <= '0;
        else if (rd_en && lane_ok && lane_n == 4'd0 && sub == SUB_CNT) shadow <= 32'(cyc_hi);
    end

    // Read data select
    always_comb begin
        rd_mux = '0;
        if (addr == GLB_OFS) begin
            rd_mux = glb_q;
        end else if (lane_ok) begin
            case (sub)
                SUB_CTLA: rd_mux = ctla_a[lane_n];
                SUB_CNT:  rd_mux = lo_a[lane_n];
                SUB_CHI:  rd_mux = (lane_n == 4'd0) ? shadow : 32'h0;
                default:  rd_mux = '0;
            endcase
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h00) |=> rdata == 32'h0);
endmodule

// File: tb/sim_evtctr_bank.sv
`timescale 1ns/1ps
module sim_evtctr_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] evt_in = '0;
    logic         irq;

    int n_run = 0;
    int n_fail = 0;
    logic  arm = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    evtctr_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata),
                    .evt_in(evt_in), .irq(irq));

    // Driver: called at a negedge, returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        n_run++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
    endtask

    // Release the global freeze for exactly n counting clocks
    task automatic run(input int n, input logic [31:0] g);
        wr(8'h40, g & 32'h7FFF_FFFF);
        repeat (n - 1) @(negedge clk);
        wr(8'h40, g | 32'h8000_0000);
    endtask

    // Monitor: a read issued at an edge is checked at the following negedge
    always @(posedge clk) arm <= rd_en;
    always @(negedge clk) begin
        if (arm && exp_q.size() > 0) begin
            chk(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h40, 32'h8000_0000, "R1 global reset");
        rd(8'h80, 32'h0, "R1 lane3 ctl reset");
        rd(8'h58, 32'h0, "R1 cycle count reset");
        chk({31'b0, irq}, 32'h0, "R1 irq reset");

        // Lane setup: 1 on code 20, 2 on code 0, 3 on quiet code 33, 4 frozen
        evt_in[20] = 1'b1;
        wr(8'h50, 32'h0005_0000);             // lane0 code 5, ignored (R4)
        wr(8'h60, 32'h0014_0000);
        wr(8'h70, 32'h0000_0000);
        wr(8'h80, 32'h0021_0000);
        wr(8'h90, 32'h8014_0000);
        wr(8'h64, 32'hFFFF_FFFF);             // spare word, ignored (R2)
        run(10, 32'h0);
        rd(8'h58, 32'd10, "R4 cycle lane counts all unfrozen clocks");
        rd(8'h68, 32'd10, "R5 lane1 event high");
        rd(8'h78, 32'd10, "R5 code 0 counts cycles");
        rd(8'h88, 32'd0,  "R5 quiet event line");
        rd(8'h98, 32'd0,  "R3 lane freeze");
        rd(8'h60, 32'h0014_0000, "R2 ctl read-back");
        rd(8'h64, 32'h0, "R2 spare word reads zero");
        rd(8'h90, 32'h8014_0000, "R2 ctl freeze bit");

        // R6 / R10 software load and cycle-counter halves
        wr(8'h68, 32'h0000_1234);
        rd(8'h68, 32'h0000_1234, "R6 count load");
        wr(8'h5C, 32'h0000_000A);
        wr(8'h58, 32'h0000_0005);
        rd(8'h58, 32'h5, "R6 lower half load");
        rd(8'h5C, 32'hA, "R10 upper via holding reg");
        wr(8'h5C, 32'h0000_0007);
        rd(8'h5C, 32'hA, "R10 holding reg unchanged without lower read");
        rd(8'h58, 32'h5, "R10 lower read");
        rd(8'h5C, 32'h7, "R10 holding reg refreshed");

        // R6 load wins over a same-clock increment
        wr(8'h40, 32'h0);
        wr(8'h78, 32'd100);
        wr(8'h40, 32'h8000_0000);
        rd(8'h78, 32'd101, "R6 load over increment");

        // R7 / R8 overflow with all enables
        wr(8'h60, 32'h0414_0000);
        wr(8'h68, 32'h7FFF_FFFE);
        wr(8'h58, 32'h0);
        wr(8'h5C, 32'h0);
        wr(8'h78, 32'h0);
        wr(8'h40, 32'h6000_0000);
        repeat (5) @(negedge clk);
        rd(8'h68, 32'h8000_0000, "R7 lane stops at overflow");
        rd(8'h40, 32'hE000_0000, "R7 hardware set freeze");
        rd(8'h58, 32'd2, "R7 cycle lane frozen too");
        rd(8'h78, 32'd2, "R7 other lane frozen too");
        chk({31'b0, irq}, 32'h1, "R8 irq raised");
        wr(8'h40, 32'hE000_0000);
        chk({31'b0, irq}, 32'h1, "R8 irq held after global write");
        wr(8'h68, 32'h0);
        chk({31'b0, irq}, 32'h0, "R8 irq dropped after top bit clear");

        // R9 overflow with condition enable clear
        wr(8'h60, 32'h0014_0000);
        wr(8'h68, 32'h7FFF_FFFF);
        run(3, 32'h6000_0000);
        rd(8'h68, 32'h8000_0002, "R9 counts past overflow");
        chk({31'b0, irq}, 32'h0, "R9 no irq");

        // R11 unmapped addresses
        rd(8'h00, 32'h0, "R11 offset 0x00");
        rd(8'h44, 32'h0, "R11 offset 0x44");
        rd(8'hFC, 32'h0, "R11 upper slot of lane 10");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule